// File: doc/BRIEF.md
# Serial Character Transmitter with Initialize Control

This block turns parallel characters into an asynchronous serial stream. Software writes a character into a single holding buffer. When transmission is enabled, the buffer is full and the clear-to-send input allows it, the character moves into a shift register at a bit boundary. The shift register then drives the line one bit per baud tick. The bit rate comes from an external `baud_tick` strobe, which is high for one clock per bit period.

Character length is 7, 8 or 9 bits. A parity bit, even or odd, can be added, and the frame ends with one or two stop bits. Two status outputs tell software when it may write again (`buf_empty`) and when the line has drained (`tx_done`).

Two control actions never truncate a frame on the line.
- Clearing the enable lets the current frame finish, then holds any buffered character.
- The initialize action clears the enable at once. When the current frame ends, it discards the buffered character and forces both status bits high. After that, nothing is sent until the enable is set again and a fresh character is written.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `tx_done` is 1, `tx_en` is 0 and `init_flag` is 0.
- R2: A frame is a low start bit, then the data bits LSB first, then the parity bit when `cfg_par_en`=1, then one stop bit (`cfg_two_stop`=0) or two (`cfg_two_stop`=1). Stop bits are high. Every bit lasts one baud-tick period. The data length is 7 bits for `cfg_len`=0, 8 bits for 1, and 9 bits for 2 or 3. Parity makes the count of ones over data plus parity even when `cfg_par_odd`=0 and odd when it is 1.
- R3: At a bit boundary where `tx_en`=1 and the buffer is full, the buffer moves into the shift register and `buf_empty` rises. A character written during a frame starts right after that frame's last stop bit, with no idle gap.
- R4: A `wr_en` pulse fills the buffer, so `buf_empty` and `tx_done` both drop on the next clock.
- R5: `tx_done` rises when the last stop bit ends and the buffer is empty. It stays 0 while a character waits in the buffer.
- R6: Clearing the enable during a frame lets that frame finish. No further character is loaded, and a buffered character stays in place (`buf_empty`=0) until the enable is set again.
- R7: A control write with `ctl_init`=1 clears `tx_en` on the next clock. `init_flag` is 1 for exactly that one clock and then returns to 0 by itself.
- R8: After an initialize, the frame in progress completes in full. When it ends, the buffered character is discarded and the status reads 0x03, that is `buf_empty`=1 and `tx_done`=1.
- R9: After an initialize, setting the enable alone sends nothing. The next frame goes out only after the buffer is written again.
- R10: With `CTS_GATE`=1, `cts_n`=1 prevents a new frame from starting, but never stops a frame already on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe per bit period |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value written by a control write |
| ctl_init | input | 1 | Initialize request written by a control write |
| cfg_len | input | 2 | Character length: 0 = 7, 1 = 8, 2 or 3 = 9 bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cts_n | input | 1 | Clear-to-send, active low |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 9 | Character to transmit |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Transmit buffer empty |
| tx_done | output | 1 | Line drained, nothing pending |
| tx_en | output | 1 | Current enable state |
| init_flag | output | 1 | Initialize bit, high for one clock |

## Verification
The hardest state to reach from the ports is an initialize that arrives while one character is on the line and a second one is waiting in the buffer. In that state the block must finish the first frame, drop the second character, report 0x03, and then ignore a re-enable that comes without a new write.

The bench gets there by writing a character and waiting for the start bit on `txd`. It then writes a second character and issues the initialize while the first frame is still shifting. A scoreboard records only the characters that must appear, so a frame from the dropped character is reported as unexpected.

The same approach covers three other conditions:
- a disable during a frame;
- clear-to-send removed during a frame;
- a write that lands while a frame is shifting, which checks the back-to-back start.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int DATA_MAX  = 9;
  localparam int FRAME_MAX = DATA_MAX + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    LEN_7  = 2'd0,
    LEN_8  = 2'd1,
    LEN_9  = 2'd2,
    LEN_9B = 2'd3
  } char_len_e;

  function automatic int data_bits(input logic [1:0] len);
    case (char_len_e'(len))
      LEN_7:   data_bits = 7;
      LEN_8:   data_bits = 8;
      default: data_bits = 9;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] len,
                                                  input logic par_en,
                                                  input logic two_stop);
    int n;
    n = 2 + data_bits(len) + (par_en ? 1 : 0) + (two_stop ? 1 : 0);
    frame_bits = CNT_W'(n);
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_MAX-1:0] d,
                                                       input logic [1:0] len,
                                                       input logic par_en,
                                                       input logic par_odd);
    logic [FRAME_MAX-1:0] f;
    logic                 p;
    int                   n;
    n = data_bits(len);
    f = '1;
    f[0] = 1'b0;
    p = par_odd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (par_en) f[n+1] = p;
    build_frame = f;
  endfunction

endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_en,
  input  logic ctl_init,
  input  logic boundary,
  output logic tx_en,
  output logic init_flag,
  output logic init_pend,
  output logic init_apply
);

  logic en_q, en_d;
  logic flag_q, flag_d;
  logic pend_q, pend_d;
  logic init_wr;

  assign init_wr    = ctl_wr && ctl_init;
  assign init_apply = pend_q && boundary;

  always_comb begin
    en_d = en_q;
    if (ctl_wr) en_d = ctl_en && !ctl_init;
  end

  always_comb begin
    flag_d = init_wr;
  end

  always_comb begin
    pend_d = pend_q;
    if (init_apply) pend_d = 1'b0;
    if (init_wr)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign tx_en     = en_q;
  assign init_flag = flag_q;
  assign init_pend = pend_q;

  // R7
  init_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_flag |-> !tx_en);

  // R7
  init_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_flag && !init_wr) |=> !init_flag);

  // R8
  init_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_flag |-> init_pend);

endmodule

// File: rtl/serial_tx_buf.sv
module serial_tx_buf
  import serial_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                load,
  input  logic                discard,
  input  logic                frame_end,
  output logic [DATA_MAX-1:0] data,
  output logic                empty,
  output logic                done
);

  logic [DATA_MAX-1:0] data_q, data_d;
  logic                empty_q, empty_d;
  logic                done_q, done_d;

  always_comb begin
    data_d = data_q;
    if (wr_en) data_d = wr_data;
  end

  always_comb begin
    empty_d = empty_q;
    if (load)    empty_d = 1'b1;
    if (discard) empty_d = 1'b1;
    if (wr_en)   empty_d = 1'b0;
  end

  always_comb begin
    done_d = done_q;
    if (frame_end && empty_q) done_d = 1'b1;
    if (load)                 done_d = 1'b0;
    if (discard)              done_d = 1'b1;
    if (wr_en)                done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      data_q  <= data_d;
      empty_q <= empty_d;
      done_q  <= done_d;
    end
  end

  assign data  = data_q;
  assign empty = empty_q;
  assign done  = done_q;

  // R3
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> empty);

  // R4
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!empty && !done));

  // R5
  done_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> empty);

endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
  import serial_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [CNT_W-1:0]     nbits,
  output logic                 busy,
  output logic                 txd,
  output logic                 frame_end
);

  logic [FRAME_MAX-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 busy_q, busy_d;
  logic                 step;

  assign step      = busy_q && baud_tick;
  assign frame_end = step && (cnt_q == CNT_W'(1));

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    if (load) begin
      shift_d = frame;
      cnt_d   = nbits;
      busy_d  = 1'b1;
    end else if (step) begin
      shift_d = {1'b1, shift_q[FRAME_MAX-1:1]};
      cnt_d   = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? shift_q[0] : 1'b1;

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R5
  frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !load) |=> !busy);

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter bit CTS_GATE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                ctl_wr,
  input  logic                ctl_en,
  input  logic                ctl_init,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                cts_n,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_done,
  output logic                tx_en,
  output logic                init_flag
);

  logic                 busy;
  logic                 frame_end;
  logic                 boundary;
  logic                 init_pend;
  logic                 init_apply;
  logic                 load;
  logic                 cts_ok;
  logic [DATA_MAX-1:0]  buf_data;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     nbits;

  generate
    if (CTS_GATE) begin : g_cts
      assign cts_ok = !cts_n;
    end else begin : g_no_cts
      assign cts_ok = 1'b1;
    end
  endgenerate

  assign boundary = !busy || frame_end;
  assign load     = baud_tick && boundary && tx_en && !buf_empty && cts_ok && !init_pend;
  assign frame    = build_frame(buf_data, cfg_len, cfg_par_en, cfg_par_odd);
  assign nbits    = frame_bits(cfg_len, cfg_par_en, cfg_two_stop);

  serial_tx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_en     (ctl_en),
    .ctl_init   (ctl_init),
    .boundary   (boundary),
    .tx_en      (tx_en),
    .init_flag  (init_flag),
    .init_pend  (init_pend),
    .init_apply (init_apply)
  );

  serial_tx_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load      (load),
    .discard   (init_apply),
    .frame_end (frame_end),
    .data      (buf_data),
    .empty     (buf_empty),
    .done      (tx_done)
  );

  serial_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load      (load),
    .frame     (frame),
    .nbits     (nbits),
    .busy      (busy),
    .txd       (txd),
    .frame_end (frame_end)
  );

  // R8
  init_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_apply && !wr_en) |=> (buf_empty && tx_done));

  // R6
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);

  // R9
  init_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pend && frame_end) |=> !busy);

  generate
    if (CTS_GATE) begin : g_cts_chk
      // R10
      cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_n && !busy) |=> !busy);
    end
  endgenerate

endmodule

// File: tb/serial_tx_core_test.sv
module serial_tx_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int BAUD_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, baud_tick;
  logic       ctl_wr, ctl_en, ctl_init;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic       cts_n, wr_en;
  logic [8:0] wr_data;
  logic       txd, buf_empty, tx_done, tx_en, init_flag;

  int errors = 0;
  int checks = 0;
  int frames = 0;
  int blen = 8, bpar = 0, bodd = 0, bstop = 1;
  logic [8:0] expq[$];

  serial_tx_core uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_init(ctl_init),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cts_n(cts_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
    .tx_en(tx_en), .init_flag(init_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int div = 0;
  always @(posedge clk) begin
    div       <= (div == BAUD_DIV-1) ? 0 : div + 1;
    baud_tick <= (div == BAUD_DIV-1);
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // Monitor: decodes frames from txd and compares against the scoreboard
  always begin
    @(negedge clk);
    if (rst_n === 1'b1 && txd === 1'b0) begin
      logic [8:0] got;
      logic       pbit;
      logic       stop_ok;
      logic [8:0] exp;
      logic [8:0] mask;
      got = '0;
      pbit = 1'b0;
      stop_ok = 1'b1;
      @(negedge clk);
      for (int i = 0; i < blen; i++) begin
        repeat (BAUD_DIV) @(negedge clk);
        got[i] = txd;
      end
      if (bpar != 0) begin
        repeat (BAUD_DIV) @(negedge clk);
        pbit = txd;
      end
      for (int s = 0; s < bstop; s++) begin
        repeat (BAUD_DIV) @(negedge clk);
        if (txd !== 1'b1) stop_ok = 1'b0;
      end
      frames++;
      if (expq.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 unexpected frame actual=%0h expected=none", got);
      end else begin
        exp  = expq.pop_front();
        mask = 9'((1 << blen) - 1);
        check("R2 data", got, exp & mask);
        if (bpar != 0)
          check("R2 parity", 9'(pbit), 9'(((^(exp & mask)) ^ bodd[0])));
        check("R2 stop", 9'(stop_ok), 9'd1);
      end
    end
  end

  task automatic set_cfg(input int len, input int par, input int odd, input int nstop);
    @(negedge clk);
    blen = len; bpar = par; bodd = odd; bstop = nstop;
    cfg_len      = (len == 7) ? 2'd0 : (len == 8) ? 2'd1 : 2'd2;
    cfg_par_en   = (par != 0);
    cfg_par_odd  = (odd != 0);
    cfg_two_stop = (nstop == 2);
  endtask

  task automatic ctl(input logic en, input logic init);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = en; ctl_init = init;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_en = 1'b0; ctl_init = 1'b0;
  endtask

  task automatic write_buf(input logic [8:0] d, input bit expect_tx);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (expect_tx) expq.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (txd !== 1'b0);
  endtask

  task automatic drain(input int extra);
    wait (expq.size() == 0);
    repeat (extra) @(negedge clk);
  endtask

  initial begin
    int f0;
    int gap;
    rst_n = 1'b0; baud_tick = 1'b0;
    ctl_wr = 0; ctl_en = 0; ctl_init = 0;
    cfg_len = 2'd1; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
    cts_n = 1'b0; wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txd", 9'(txd), 9'd1);
    check("R1 buf_empty", 9'(buf_empty), 9'd1);
    check("R1 tx_done", 9'(tx_done), 9'd1);
    check("R1 tx_en", 9'(tx_en), 9'd0);
    check("R1 init_flag", 9'(init_flag), 9'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 8N1, R4 write clears status
    set_cfg(8, 0, 0, 1);
    ctl(1'b1, 1'b0);
    cts_n = 1'b1;
    write_buf(9'h0A5, 1'b1);
    check("R4 buf_empty after write", 9'(buf_empty), 9'd0);
    check("R4 tx_done after write", 9'(tx_done), 9'd0);
    cts_n = 1'b0;
    drain(12);
    check("R5 tx_done after frame", 9'(tx_done), 9'd1);

    // R3 back-to-back with no gap
    write_buf(9'h03C, 1'b1);
    wait_start();
    write_buf(9'h0C3, 1'b1);
    check("R3 buf full while shifting", 9'(buf_empty), 9'd0);
    wait (expq.size() == 1);
    gap = 0;
    while (txd !== 1'b0 && gap < 10) begin
      @(negedge clk);
      gap++;
    end
    check("R3 no idle gap", 9'(gap <= BAUD_DIV), 9'd1);
    check("R3 buf_empty after load", 9'(buf_empty), 9'd1);
    drain(12);

    // R2 seven bits, even parity, two stops
    set_cfg(7, 1, 0, 2);
    write_buf(9'h05B, 1'b1);
    drain(12);
    write_buf(9'h1FF, 1'b1);
    drain(12);
    // R2 nine bits, odd parity
    set_cfg(9, 1, 1, 1);
    write_buf(9'h1A6, 1'b1);
    drain(12);
    write_buf(9'h100, 1'b1);
    drain(12);

    // R6 disable mid-frame
    set_cfg(8, 1, 0, 1);
    write_buf(9'h055, 1'b1);
    wait_start();
    write_buf(9'h0AA, 1'b0);
    ctl(1'b0, 1'b0);
    drain(60);
    check("R6 buffered char kept", 9'(buf_empty), 9'd0);
    check("R5 done low with char waiting", 9'(tx_done), 9'd0);
    expq.push_back(9'h0AA);
    ctl(1'b1, 1'b0);
    drain(12);
    check("R6 resumed after enable", 9'(tx_done), 9'd1);

    // R7/R8 initialize mid-frame with a char waiting
    write_buf(9'h0E1, 1'b1);
    wait_start();
    write_buf(9'h01E, 1'b0);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = 1'b1; ctl_init = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_en = 1'b0; ctl_init = 1'b0;
    check("R7 init_flag set", 9'(init_flag), 9'd1);
    check("R7 tx_en cleared", 9'(tx_en), 9'd0);
    @(negedge clk);
    check("R7 init_flag self clear", 9'(init_flag), 9'd0);
    check("R8 frame still running", 9'(txd === 1'b1 && buf_empty === 1'b1), 9'd0);
    drain(12);
    check("R8 status 0x03", {7'd0, tx_done, buf_empty}, 9'h003);

    // R9 enable alone sends nothing
    f0 = frames;
    ctl(1'b1, 1'b0);
    repeat (80) @(negedge clk);
    check("R9 no frame without write", 9'(frames - f0), 9'd0);
    check("R9 buf still empty", 9'(buf_empty), 9'd1);
    write_buf(9'h077, 1'b1);
    drain(12);
    check("R9 frame after write", 9'(frames - f0), 9'd1);

    // R10 clear-to-send gating
    cts_n = 1'b1;
    f0 = frames;
    write_buf(9'h012, 1'b1);
    repeat (80) @(negedge clk);
    check("R10 held by cts", 9'(frames - f0), 9'd0);
    check("R10 buf kept", 9'(buf_empty), 9'd0);
    cts_n = 1'b0;
    drain(12);
    write_buf(9'h0F0, 1'b1);
    wait_start();
    cts_n = 1'b1;
    drain(12);
    check("R10 frame completed under cts", 9'(tx_done), 9'd1);
    cts_n = 1'b0;

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule